// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management-bus master for PHY or SerDes register access. Software sees two 32-bit registers on a simple write/read port. The control register holds the management clock divisor, a preamble enable and a sticky completion flag. The data register holds a complete Clause-22 frame, laid out bit for bit, and writing it starts the frame.

The controller drives MDC and shifts the frame onto MDIO, most significant bit first. When the preamble is enabled, 32 one-bits go out before the frame. Bit 29 of the frame marks a read. For a read frame the controller releases MDIO from the second turnaround bit onward. It then shifts the 16 bits returned by the device into bits 15:0 of the data register. Software polls the completion flag and then writes zero to the control register to park the engine. Extended-address devices are reached with a PHY-select frame sent before the real access. This is an ordinary write frame to register 0x1F with the PHY number in the data field.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low, and both the control register and the data register read as zero.
- R2: A data-register write (register select 1) while the engine is enabled starts a frame and clears the completion flag (control bit 8) in the next cycle. The engine is enabled while control bit 7 or any divisor bit is set.
- R3: With control bit 7 clear, exactly 32 bits go out, data bits 31 down to 0. With control bit 7 set, 32 one-bits go out first, then the same 32 bits.
- R4: MDC starts low. Its period is 2×(D+1) system clocks, where D is the divisor held in control bits 3:0.
- R5: MDIO output changes only when MDC falls or when a frame starts, never while MDC is high.
- R6: A frame with data bit 29 set is a read. The output enable is low from frame bit 16 to the end of the frame. The 16 values of the MDIO input sampled at the MDC rising edges of frame bits 15..0 land in data bits 15:0, first sampled bit in bit 15. Data bits 31:16 keep the written value.
- R7: A frame with data bit 29 clear keeps the output enable high for every bit and leaves the data register unchanged. A PHY-select frame (register field 0x1F, PHY number at data bit 4) is one such frame.
- R8: When the last bit period ends, the completion flag sets and stays set until the next frame starts. MDC and the output enable then stay low.
- R9: Writing zero to control bits 7:0 while a frame is running stops it at once. MDC and the output enable go low, and the completion flag stays clear.
- R10: A data-register write while a frame is running is ignored. Neither the frame on the wire nor the data register changes.
- R11: A data-register write while the engine is disabled stores the value but sends nothing. MDC stays low and the completion flag is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that the register port issues at most one write per cycle. They also assume that a control write during a frame is either a full stop (zero in bits 7:0) or absent. A divisor change in mid-frame is legal but stretches one half period, and no property models it. The stimulus follows this: it changes the divisor only between frames and uses the control register during a frame only to stop the engine. The device model drives MDIO only inside the 16 read data bits and holds it high elsewhere, as a pull-up would.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 4,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME = 32;
  localparam int SH_W  = PRE_BITS + FRAME;
  localparam int REM_W = $clog2(SH_W + 1);

  logic [DIV_W-1:0] div_q, tick_q;
  logic             pre_q, done_q, busy, rd_q;
  logic [31:0]      data_q;
  logic [SH_W-1:0]  sh_q;
  logic [REM_W-1:0] rem_q;

  wire enabled = pre_q || (div_q != '0);
  wire ctl_wr  = reg_wr && !reg_addr;
  wire dat_wr  = reg_wr && reg_addr;
  wire stop    = ctl_wr && !reg_wdata[7] && (reg_wdata[DIV_W-1:0] == '0);
  wire start   = dat_wr && enabled && !busy;
  wire tick    = busy && (tick_q >= div_q);
  wire rise    = tick && !mdc;
  wire fall    = tick && mdc;
  wire in_rx   = rd_q && (rem_q <= REM_W'(16));

  assign mdio_o    = busy && sh_q[SH_W-1];
  assign mdio_oe   = busy && !(rd_q && rem_q <= REM_W'(17));
  assign reg_rdata = reg_addr ? data_q : {23'd0, done_q, pre_q, 7'(div_q)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
      busy   <= 1'b0;
      rd_q   <= 1'b0;
      mdc    <= 1'b0;
      data_q <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
    end else begin
      if (ctl_wr) begin
        div_q <= reg_wdata[DIV_W-1:0];
        pre_q <= reg_wdata[7];
      end
      if (start) begin
        data_q <= reg_wdata;
        busy   <= 1'b1;
        done_q <= 1'b0;
        mdc    <= 1'b0;
        tick_q <= '0;
        rd_q   <= reg_wdata[29];
        sh_q   <= pre_q ? {{PRE_BITS{1'b1}}, reg_wdata} : {reg_wdata, {PRE_BITS{1'b0}}};
        rem_q  <= pre_q ? REM_W'(SH_W) : REM_W'(FRAME);
      end else if (dat_wr && !busy) begin
        data_q <= reg_wdata;
      end else if (stop) begin
        busy   <= 1'b0;
        mdc    <= 1'b0;
        tick_q <= '0;
      end else if (busy) begin
        tick_q <= tick ? '0 : tick_q + 1'b1;
        if (tick) mdc <= !mdc;
        if (rise && in_rx) data_q[15:0] <= {data_q[14:0], mdio_i};
        if (fall) begin
          sh_q  <= sh_q << 1;
          rem_q <= rem_q - 1'b1;
          if (rem_q == REM_W'(1)) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        done_q,
  input logic        rd_q,
  input logic        reg_wr,
  input logic        reg_addr,
  input logic [31:0] data_q
);
  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done_q);

  assert_mdio_quiet_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));

  assert_write_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !rd_q) |-> $stable(data_q));

  assert_idle_lines_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_finish_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(reg_wr && !reg_addr)) |-> done_q);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .done_q(done_q), .rd_q(rd_q), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .data_q(data_q)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [63:0] tx;
    logic [63:0] oe;
    int          nbits;
    logic [31:0] data_after;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0, n_bad = 0;
  logic [15:0] resp = '0;
  int          pre_len = 0;
  bit          rd_frame = 0;
  int          exp_period = 2;
  logic [63:0] got_tx, got_oe;
  int          got_n = 0, last_rise = 0, cyc = 0, bad_period = 0, r5_viol = 0;
  logic [31:0] got_data;
  event        frame_end;

  assign mdio_i = (rd_frame && got_n >= pre_len + 16 && got_n < pre_len + 32) ?
                  resp[pre_len + 31 - got_n] : 1'b1;

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    got_tx = {got_tx[62:0], mdio_o & mdio_oe};
    got_oe = {got_oe[62:0], mdio_oe};
    if (got_n > 0 && (cyc - last_rise) != exp_period) bad_period++;
    last_rise = cyc;
    got_n++;
  end

  always @(mdio_o) if (mdc) r5_viol++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_tx = '0; got_oe = '0; got_n = 0; bad_period = 0; r5_viol = 0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a;
    #0.1 d = reg_rdata;
  endtask

  initial forever begin
    exp_t e;
    @(frame_end);
    e = sb.pop_front();
    chk("R3 bit count", 64'(got_n), 64'(e.nbits));
    chk("R3/R6/R7 wire bits", got_tx, e.tx);
    chk("R6/R7 output enable", got_oe, e.oe);
    chk("R4 MDC period", 64'(bad_period), 64'd0);
    chk("R5 MDIO stable while MDC high", 64'(r5_viol), 64'd0);
    chk("R6/R7 data after frame", 64'(got_data), 64'(e.data_after));
  end

  task automatic run_frame(input logic [31:0] w, input bit pre, input logic [3:0] dv,
                           input logic [15:0] r, input bit inject);
    exp_t        e;
    logic [31:0] v;
    int          t;
    wr(1'b0, {24'd0, pre, 3'd0, dv});
    clear_mon();
    resp = r; pre_len = pre ? 32 : 0; rd_frame = w[29]; exp_period = 2 * (int'(dv) + 1);
    e.tx = '0; e.oe = '0; e.nbits = pre_len + 32;
    for (int i = 0; i < pre_len; i++) begin
      e.tx = {e.tx[62:0], 1'b1}; e.oe = {e.oe[62:0], 1'b1};
    end
    for (int i = 0; i < 32; i++) begin
      bit o;
      o = !(w[29] && i >= 15);
      e.tx = {e.tx[62:0], o & w[31-i]}; e.oe = {e.oe[62:0], o};
    end
    e.data_after = w[29] ? {w[31:16], r} : w;
    sb.push_back(e);
    wr(1'b1, w);
    rd(1'b0, v);
    chk("R2 done cleared at start", 64'(v[8]), 64'd0);
    if (inject) begin
      repeat (10) @(negedge clk);
      wr(1'b1, ~w);
    end
    t = 0;
    rd(1'b0, v);
    while (!v[8] && t < 5000) begin
      @(negedge clk); rd(1'b0, v); t++;
    end
    rd(1'b1, got_data);
    -> frame_end;
    @(negedge clk);
    repeat (20) @(negedge clk);
    rd(1'b0, v);
    chk("R8 done sticky", 64'(v[8]), 64'd1);
    chk("R8 idle lines", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mdc/oe after reset", {62'd0, mdc, mdio_oe}, 64'd0);
    rd(1'b0, v); chk("R1 control after reset", 64'(v), 64'd0);
    rd(1'b1, v); chk("R1 data after reset", 64'(v), 64'd0);

    // R7: write frame, no preamble, divisor 2
    run_frame(32'h5A5A_C3F0 & 32'hDFFF_FFFF | 32'h5000_0000, 1'b0, 4'd2, 16'h0, 1'b0);
    // R3: preamble, divisor 1
    run_frame(32'h5283_ABCD, 1'b1, 4'd1, 16'h0, 1'b0);
    // R6: read frame, divisor 0 with preamble
    run_frame(32'h60A6_0000, 1'b1, 4'd0, 16'hB2E5, 1'b0);
    // R6: read frame, no preamble, divisor 3
    run_frame(32'h6F7E_1234, 1'b0, 4'd3, 16'h4C1A, 1'b0);
    // R7: PHY-select frame to register 0x1F, PHY 5 at data bit 4
    run_frame(32'h507E_0050, 1'b0, 4'd1, 16'h0, 1'b0);
    // R10: data write during a frame is ignored
    run_frame(32'h5123_8001, 1'b0, 4'd2, 16'h0, 1'b1);

    // R9: stop a running frame
    wr(1'b0, 32'h0000_0004);
    wr(1'b1, 32'h6000_0000);
    repeat (30) @(negedge clk);
    wr(1'b0, 32'h0);
    chk("R9 lines low after stop", {62'd0, mdc, mdio_oe}, 64'd0);
    repeat (40) @(negedge clk);
    rd(1'b0, v); chk("R9 done stays clear", 64'(v), 64'd0);
    chk("R9 mdc still low", 64'(mdc), 64'd0);

    // R11: disabled engine stores data, sends nothing
    clear_mon();
    wr(1'b1, 32'h1234_5678);
    repeat (50) @(negedge clk);
    chk("R11 no MDC edges", 64'(got_n), 64'd0);
    rd(1'b1, v); chk("R11 data stored", 64'(v), 64'h1234_5678);
    rd(1'b0, v); chk("R11 control unchanged", 64'(v), 64'd0);

    finish_run();
  end
endmodule